// File: doc/BRIEF.md
# Bridged Bus Command Status Unit

This unit connects a register port with 64-bit data to a simple request/acknowledge peripheral bus. Software starts one downstream transfer by writing a single packed command word. That word carries the direction, the transfer size, a 24-bit address and, for writes, 32 bits of data. The unit then holds the request on the downstream bus until the target acknowledges it or reports an error.

The outcome is collected in a live status word. It shows busy, read-data-valid, and three groups of error bits: one for the downstream bus and one for each of two port controllers. A read of the status register returns the status word in the upper half and the captured read data in the lower half. Writing zero to the status register clears it. A second register keeps a copy of the status taken at the moment each transfer completes, so that the outcome of the last transfer stays visible after software has cleared the live status.

Top module: `bus_cmd_bridge`

## Requirements
- R1: A write to register offset 0 while idle is accepted. In the next cycle, status bit 16 (busy) is 1 and bus_req_o is 1. The bus fields come from the command word, which is the upper 32 bits of the write: bus_we_o is bit 31, bus_size_o is bits 30:29 (00 = 8-bit, 01 = 16-bit, 11 = 32-bit) and bus_addr_o is bits 23:0. bus_wdata_o is the lower 32 bits of the write.
- R2: bus_req_o and all transfer fields stay constant until the cycle in which bus_ack_i or bus_err_i is high. In the following cycle, bus_req_o and the busy bit are 0.
- R3: A read that completes with bus_ack_i high and bus_err_i low sets status bit 17 (read valid), and bus_rdata_i appears in the lower 32 bits of a status read. A write completion or an error completion leaves bit 17 at 0. Accepting a new command clears bit 17.
- R4: An error completion sets one status bit chosen by bus_err_src_i. Source 0 or 3 (downstream bus) sets bit 20. Source 1 (first port controller) sets bit 10 + min(code, 5). Source 2 (second port controller) sets bit 2 + min(code, 5). Here code is bus_err_code_i. If error and acknowledge are both high, the transfer counts as an error. Error bits accumulate until cleared.
- R5: A command write that arrives while busy is ignored: the transfer in flight and its fields do not change. It also sets status bit 27, which lies in the downstream-bus error group.
- R6: Writing the value zero to offset 1 clears the error bits, bit 17 and the captured read data, and leaves busy unchanged. A non-zero write to offset 1 has no effect.
- R7: Offset 2 returns, in its upper 32 bits, the status word captured at completion (busy bit 0). Its lower 32 bits are 0. Clearing the live status does not change it.
- R8: After reset, every register reads zero and bus_req_o is 0. Offsets 0 and 3 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_off_i | input | 2 | Register offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, selected by reg_off_i |
| bus_req_o | output | 1 | Downstream request, held until response |
| bus_we_o | output | 1 | Downstream direction, 1 = write |
| bus_size_o | output | 2 | Downstream transfer size code |
| bus_addr_o | output | 24 | Downstream address |
| bus_wdata_o | output | 32 | Downstream write data |
| bus_ack_i | input | 1 | Downstream acknowledge |
| bus_err_i | input | 1 | Downstream error response |
| bus_err_src_i | input | 2 | Error source: 0/3 bus, 1 port controller A, 2 port controller B |
| bus_err_code_i | input | 3 | Error code within the port-controller group |
| bus_rdata_i | input | 32 | Downstream read data |

## Verification
The bench issues a command while another is in flight. A design that reloaded the transfer would visibly change bus_addr_o and lose bit 27. It zeroes the live status while a transfer is busy and then writes a non-zero value. A faulty clear would either drop busy or react to the non-zero write. It raises acknowledge and error together to catch a design that sets read-valid on a failed read. It uses error code 7 to catch clamping that spills outside its group. Finally, it reads the latched register after clearing, which exposes a copy that is shared with, or cleared along with, the live status.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 32;
  localparam int REG_W     = 64;
  localparam int ST_W      = 32;
  localparam int CMD_DIR   = 31;
  localparam int CMD_SZ_HI = 30;
  localparam int CMD_SZ_LO = 29;
  localparam int ST_BUSY   = 16;
  localparam int ST_RVALID = 17;
  localparam int ST_BUSERR = 20;
  localparam int ST_OVLP   = 27;
  localparam int ST_PA_LSB = 10;
  localparam int ST_PB_LSB = 2;
  localparam int GRP_BITS  = 6;

  typedef enum logic [1:0] {
    OFF_CMD   = 2'd0,
    OFF_STAT  = 2'd1,
    OFF_LATCH = 2'd2,
    OFF_RSVD  = 2'd3
  } reg_off_e;

  typedef enum logic [1:0] {
    SRC_BUS_A = 2'd0,
    SRC_PC_A  = 2'd1,
    SRC_PC_B  = 2'd2,
    SRC_BUS_B = 2'd3
  } err_src_e;

  typedef struct packed {
    logic              we;
    logic [1:0]        size;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } xfer_t;
endpackage

// File: rtl/bcb_cmd_dec.sv
module bcb_cmd_dec
  import bcb_pkg::*;
(
  input  logic [REG_W-1:0] wdata_i,
  output xfer_t            cmd_o
);
  logic [ST_W-1:0] word;

  assign word        = wdata_i[REG_W-1:DATA_W];
  assign cmd_o.we    = word[CMD_DIR];
  assign cmd_o.size  = word[CMD_SZ_HI:CMD_SZ_LO];
  assign cmd_o.addr  = word[ADDR_W-1:0];
  assign cmd_o.wdata = wdata_i[DATA_W-1:0];
endmodule

// File: rtl/bcb_xfer_ctrl.sv
module bcb_xfer_ctrl
  import bcb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmd_wr_i,
  input  xfer_t cmd_i,
  input  logic  ack_i,
  input  logic  err_i,
  output logic  busy_o,
  output xfer_t cmd_q_o,
  output logic  accept_o,
  output logic  collide_o,
  output logic  done_o
);
  logic  busy_q;
  xfer_t cmd_q;

  assign accept_o  = cmd_wr_i & ~busy_q;
  assign collide_o = cmd_wr_i & busy_q;
  assign done_o    = busy_q & (ack_i | err_i);
  assign busy_o    = busy_q;
  assign cmd_q_o   = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      if (accept_o) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd_i;
      end else if (done_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && (cmd_q_o == $past(cmd_i)));

  a_r2_hold_until_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ack_i && !err_i |=> busy_o && $stable(cmd_q_o));

  a_r2_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (ack_i || err_i) |=> !busy_o);

  a_r5_collide_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_o |=> $stable(cmd_q_o));
endmodule

// File: rtl/bcb_status.sv
module bcb_status
  import bcb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              collide_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic              we_q_i,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [1:0]        err_src_i,
  input  logic [2:0]        err_code_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              clr_i,
  output logic [ST_W-1:0]   status_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ST_W-1:0]   latch_o
);
  localparam logic [2:0] CODE_MAX = 3'(GRP_BITS - 1);

  logic [ST_W-1:0]   err_q, err_n, err_set;
  logic              vld_q, vld_n;
  logic [DATA_W-1:0] rd_q, rd_n;
  logic [ST_W-1:0]   latch_q;
  logic [2:0]        code_c;
  logic              rd_ok;

  assign code_c = (err_code_i > CODE_MAX) ? CODE_MAX : err_code_i;
  assign rd_ok  = done_i & ack_i & ~err_i & ~we_q_i;

  always_comb begin
    err_set = '0;
    if (collide_i) err_set[ST_OVLP] = 1'b1;
    if (done_i && err_i) begin
      unique case (err_src_e'(err_src_i))
        SRC_PC_A: err_set[ST_PA_LSB + int'(code_c)] = 1'b1;
        SRC_PC_B: err_set[ST_PB_LSB + int'(code_c)] = 1'b1;
        default:  err_set[ST_BUSERR] = 1'b1;
      endcase
    end
  end

  always_comb begin
    err_n = (clr_i ? '0 : err_q) | err_set;
    vld_n = vld_q;
    rd_n  = rd_q;
    if (clr_i || accept_i) begin
      vld_n = 1'b0;
      rd_n  = '0;
    end
    if (rd_ok) begin
      vld_n = 1'b1;
      rd_n  = rdata_i;
    end
  end

  function automatic logic [ST_W-1:0] pack_st(logic [ST_W-1:0] e, logic v, logic b);
    logic [ST_W-1:0] w;
    w            = e;
    w[ST_RVALID] = v;
    w[ST_BUSY]   = b;
    return w;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      vld_q   <= 1'b0;
      rd_q    <= '0;
      latch_q <= '0;
    end else begin
      err_q <= err_n;
      vld_q <= vld_n;
      rd_q  <= rd_n;
      if (done_i) latch_q <= pack_st(err_n, vld_n, 1'b0);
    end
  end

  assign status_o = pack_st(err_q, vld_q, busy_i);
  assign rdata_o  = rd_q;
  assign latch_o  = latch_q;

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !done_i && !collide_i |=> (status_o & ~(ST_W'(1) << ST_BUSY)) == '0 && rdata_o == '0);

  a_r7_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(latch_o));

  a_r3_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_RVALID] |-> !busy_i);

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((status_o & $past(err_q)) == $past(err_q)));

  a_r4_one_err_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(err_set) <= 2);
endmodule

// File: rtl/bus_cmd_bridge.sv
module bus_cmd_bridge
  import bcb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_off_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_size_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [1:0]        bus_err_src_i,
  input  logic [2:0]        bus_err_code_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  xfer_t             cmd_dec, cmd_q;
  logic              cmd_wr, clr, busy, accept, collide, done;
  logic [ST_W-1:0]   status, latch;
  logic [DATA_W-1:0] rd_cap;

  assign cmd_wr = reg_req_i & reg_we_i & (reg_off_e'(reg_off_i) == OFF_CMD);
  assign clr    = reg_req_i & reg_we_i & (reg_off_e'(reg_off_i) == OFF_STAT)
                & (reg_wdata_i == '0);

  bcb_cmd_dec i_dec (
    .wdata_i (reg_wdata_i),
    .cmd_o   (cmd_dec)
  );

  bcb_xfer_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr),
    .cmd_i     (cmd_dec),
    .ack_i     (bus_ack_i),
    .err_i     (bus_err_i),
    .busy_o    (busy),
    .cmd_q_o   (cmd_q),
    .accept_o  (accept),
    .collide_o (collide),
    .done_o    (done)
  );

  bcb_status i_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .collide_i  (collide),
    .done_i     (done),
    .busy_i     (busy),
    .we_q_i     (cmd_q.we),
    .ack_i      (bus_ack_i),
    .err_i      (bus_err_i),
    .err_src_i  (bus_err_src_i),
    .err_code_i (bus_err_code_i),
    .rdata_i    (bus_rdata_i),
    .clr_i      (clr),
    .status_o   (status),
    .rdata_o    (rd_cap),
    .latch_o    (latch)
  );

  assign bus_req_o   = busy;
  assign bus_we_o    = cmd_q.we;
  assign bus_size_o  = cmd_q.size;
  assign bus_addr_o  = cmd_q.addr;
  assign bus_wdata_o = cmd_q.wdata;

  always_comb begin
    unique case (reg_off_e'(reg_off_i))
      OFF_STAT:  reg_rdata_o = {status, rd_cap};
      OFF_LATCH: reg_rdata_o = {latch, {DATA_W{1'b0}}};
      default:   reg_rdata_o = '0;
    endcase
  end

  a_r1_req_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !bus_req_o |=> bus_req_o && bus_addr_o == $past(reg_wdata_i[ADDR_W+DATA_W-1:DATA_W]));

  a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_off_e'(reg_off_i) == OFF_RSVD |-> reg_rdata_o == '0);
endmodule

// File: tb/test_bus_cmd_bridge.sv
`timescale 1ns/1ps
module test_bus_cmd_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  off = 2'd0;
  logic [63:0] wd = '0, rd;
  logic        b_req, b_we;
  logic [1:0]  b_size;
  logic [23:0] b_addr;
  logic [31:0] b_wdata;
  logic        ack = 1'b0, err = 1'b0;
  logic [1:0]  src = 2'd0;
  logic [2:0]  code = 3'd0;
  logic [31:0] b_rdata = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_cmd_bridge i_bus_cmd_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_off_i(off), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .bus_req_o(b_req), .bus_we_o(b_we), .bus_size_o(b_size), .bus_addr_o(b_addr),
    .bus_wdata_o(b_wdata), .bus_ack_i(ack), .bus_err_i(err), .bus_err_src_i(src),
    .bus_err_code_i(code), .bus_rdata_i(b_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  size;
    logic [23:0] addr;
    logic [31:0] data;
    logic [3:0]  lat;
    logic        is_err;
    logic [1:0]  src;
    logic [2:0]  code;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b11, 24'h123456, 32'h0,        4'd0, 1'b0, 2'd0, 3'd0, 32'hDEADBEEF},
    '{1'b1, 2'b00, 24'hABCDEF, 32'h0000005A, 4'd3, 1'b0, 2'd0, 3'd0, 32'h0},
    '{1'b0, 2'b01, 24'h000010, 32'h0,        4'd2, 1'b1, 2'd1, 3'd2, 32'h0},
    '{1'b1, 2'b11, 24'hFFFFFF, 32'hCAFEF00D, 4'd1, 1'b1, 2'd2, 3'd7, 32'h0},
    '{1'b0, 2'b11, 24'h0F0F0F, 32'h0,        4'd5, 1'b1, 2'd0, 3'd4, 32'h0},
    '{1'b0, 2'b00, 24'h000001, 32'h0,        4'd1, 1'b1, 2'd3, 3'd0, 32'h0},
    '{1'b1, 2'b11, 24'h800000, 32'h12345678, 4'd0, 1'b1, 2'd1, 3'd5, 32'h0}
  };

  function automatic logic [31:0] err_bit(logic [1:0] s, logic [2:0] c);
    int cc = (c > 3'd5) ? 5 : int'(c);
    logic [31:0] w = '0;
    case (s)
      2'd1:    w[10 + cc] = 1'b1;
      2'd2:    w[2 + cc] = 1'b1;
      default: w[20] = 1'b1;
    endcase
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] o, logic [63:0] d);
    req = 1'b1; we = 1'b1; off = o; wd = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wd = '0;
  endtask

  task automatic rd_reg(logic [1:0] o, output logic [63:0] v);
    off = o; #0.5; v = rd;
  endtask

  task automatic respond(logic a, logic e, logic [1:0] s, logic [2:0] c, logic [31:0] d);
    ack = a; err = e; src = s; code = c; b_rdata = d;
    @(negedge clk);
    ack = 1'b0; err = 1'b0; b_rdata = '0;
  endtask

  function automatic logic [63:0] cmd_word(logic w, logic [1:0] sz, logic [23:0] a, logic [31:0] d);
    return {w, sz, 5'b0, a, d};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    for (int o = 0; o < 4; o++) begin
      rd_reg(2'(o), v);
      chk("R8 reset read", v, 64'h0);
    end
    chk("R8 reset req", {63'h0, b_req}, 64'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t t = VECS[i];
      reg_wr(2'd0, cmd_word(t.we, t.size, t.addr, t.data));
      chk("R1 req", {63'h0, b_req}, 64'h1);
      chk("R1 fields", {26'h0, b_we, b_size, b_addr, b_wdata}, {26'h0, t.we, t.size, t.addr, t.data});
      rd_reg(2'd1, v);
      chk("R1 busy status", v, 64'h00010000_00000000);
      for (int k = 0; k < int'(t.lat); k++) begin
        @(negedge clk);
        chk("R2 held", {39'h0, b_req, b_addr}, {39'h0, 1'b1, t.addr});
      end
      respond(~t.is_err, t.is_err, t.src, t.code, t.rdata);
      chk("R2 released", {63'h0, b_req}, 64'h0);
      if (t.is_err) st = err_bit(t.src, t.code);
      else st = t.we ? 32'h0 : 32'h0002_0000;
      rd_reg(2'd1, v);
      chk(t.is_err ? "R4 error status" : "R3 done status", v,
          {st, (!t.is_err && !t.we) ? t.rdata : 32'h0});
      rd_reg(2'd2, v);
      chk("R7 latched", v, {st, 32'h0});
      reg_wr(2'd1, 64'h0);
      rd_reg(2'd1, v);
      chk("R6 cleared", v, 64'h0);
      rd_reg(2'd2, v);
      chk("R7 latched after clear", v, {st, 32'h0});
    end

    // R5 collision
    reg_wr(2'd0, cmd_word(1'b0, 2'b11, 24'h00AA00, 32'h0));
    reg_wr(2'd0, cmd_word(1'b1, 2'b00, 24'h005500, 32'h77));
    chk("R5 addr unchanged", {40'h0, b_addr}, {40'h0, 24'h00AA00});
    chk("R5 dir unchanged", {63'h0, b_we}, 64'h0);
    rd_reg(2'd1, v);
    chk("R5 overlap bit", v, {32'h0801_0000, 32'h0});
    respond(1'b1, 1'b0, 2'd0, 3'd0, 32'h0000_0011);
    rd_reg(2'd1, v);
    chk("R5 overlap kept after done", v, {32'h0802_0000, 32'h0000_0011});

    // R3 accept clears valid; R6 clear while busy, non-zero write ignored
    reg_wr(2'd0, cmd_word(1'b0, 2'b01, 24'h000100, 32'h0));
    rd_reg(2'd1, v);
    chk("R3 accept clears valid", v, {32'h0801_0000, 32'h0});
    reg_wr(2'd1, 64'h0);
    rd_reg(2'd1, v);
    chk("R6 clear keeps busy", v, {32'h0001_0000, 32'h0});
    reg_wr(2'd1, 64'h0000_0000_0000_0001);
    rd_reg(2'd1, v);
    chk("R6 nonzero write ignored", v, {32'h0001_0000, 32'h0});
    respond(1'b0, 1'b1, 2'd1, 3'd0, 32'h0);
    rd_reg(2'd2, v);
    chk("R7 latch after err", v, {32'h0000_0400, 32'h0});
    reg_wr(2'd1, 64'h0);
    rd_reg(2'd2, v);
    chk("R7 latch survives clear", v, {32'h0000_0400, 32'h0});

    // R4 error and ack together on a read
    reg_wr(2'd0, cmd_word(1'b0, 2'b11, 24'h000200, 32'h0));
    respond(1'b1, 1'b1, 2'd2, 3'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, v);
    chk("R4 err wins over ack", v, {32'h0000_0008, 32'h0});
    // R4 accumulation
    reg_wr(2'd0, cmd_word(1'b1, 2'b11, 24'h000300, 32'h1));
    respond(1'b0, 1'b1, 2'd0, 3'd0, 32'h0);
    rd_reg(2'd1, v);
    chk("R4 errors accumulate", v, {32'h0010_0008, 32'h0});

    // R8 offsets 0 and 3 read zero after activity
    rd_reg(2'd0, v);
    chk("R8 offset0 zero", v, 64'h0);
    rd_reg(2'd3, v);
    chk("R8 offset3 zero", v, 64'h0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule